// File: doc/BRIEF.md
# Two-Phase Mailbox Doorbell

This block is the device-side doorbell through which a host posts one command at a time. The command is described by a mailbox structure in host memory, and its 64-bit address arrives in two writes to the same 32-bit register. The first write sets the high-phase flag and carries the upper address field. The block acknowledges that write after a fixed delay by raising its ready flag. The second write has the high-phase flag clear, carries the lower address field, and launches the command.

On launch the block sends a one-cycle start strobe, together with the assembled address, to a command engine. The ready flag stays low until the engine reports completion. At that point the mailbox holds a valid completion entry and the host may read it. Writes that break the two-step order are discarded and set a sticky protocol-error flag. Writes that arrive while a command is running are discarded without any other effect.

Top module: `mbox_doorbell`

## Requirements
- R1: After reset, the read value shows ready (bit 0) = 1, expecting-low-half (bit 1) = 0, protocol error (bit 2) = 0, all other read bits 0, and cmdStart low.
- R2: A write with bit 1 = 1, accepted while the block is idle or waiting for the low half, latches wrData[31:2] as the upper field. Ready then reads 0 for exactly ACK_CYCLES cycles after the write edge. After that, ready reads 1 and bit 1 reads 1.
- R3: A write with bit 1 = 0 that arrives while bit 1 reads 1 and ready reads 1 is accepted. In the cycle after the write edge, cmdStart is high for exactly one cycle. During that cycle, cmdAddr equals {upper field, lower field wrData[31:2], 4'b0000}.
- R4: From the accepted low-half write until cmdDone is sampled high, ready reads 0. On the edge that samples cmdDone, the block returns to idle: ready reads 1 and bit 1 reads 0.
- R5: A write with bit 1 = 0 arrives while no acknowledged upper field is held, that is in idle or during the acknowledge delay. Such a write produces no cmdStart and does not change ready or bit 1. It sets bit 2.
- R6: Any write while a command is in flight is dropped. It produces no cmdStart, cmdAddr stays unchanged, ready stays 0, and bit 2 is not set.
- R7: A write with bit 1 = 1 while the block waits for the low half replaces the upper field and restarts the acknowledge delay. The next command uses the new upper field.
- R8: cmdDone is ignored when no command is in flight.
- R9: Once set, the protocol-error flag stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Write data: [31:2] address field, [1] high-phase flag |
| rdData | output | 32 | Read value: [0] ready, [1] expecting low half, [2] protocol error |
| cmdStart | output | 1 | One-cycle command launch strobe |
| cmdAddr | output | 64 | Assembled mailbox address |
| cmdDone | input | 1 | Completion from the command engine |

## Verification
The bench builds the block with ACK_CYCLES = 3. This makes the acknowledge window long enough to place a low-half write inside it, and to re-issue a high-half write that restarts the delay. The default 32-bit register and 4 implied zero bits give a full 64-bit address. Random 30-bit fields then exercise every address bit of both halves. Random completion latencies keep the engine busy long enough for stray writes and early completions to land in every state.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HI_WAIT,
    ST_ARMED,
    ST_BUSY
  } mboxState_t;

  typedef struct packed {
    logic loadHi;
    logic loadLo;
  } mboxStrobe_t;

  localparam int RDY_BIT = 0;
  localparam int HI_BIT  = 1;
  localparam int ERR_BIT = 2;
  localparam int FLAG_BITS = 2;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ACK_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrHi,
  input  logic        cmdDone,
  output mboxStrobe_t strobe,
  output logic        ready,
  output logic        expectLo,
  output logic        protoErr,
  output logic        cmdStart,
  output logic        busy
);
  localparam int CNT_W = (ACK_CYCLES < 2) ? 1 : $clog2(ACK_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACK_CYCLES - 1);

  mboxState_t state, stateNext;
  logic [CNT_W-1:0] ackCnt;
  logic hiWrite, loWrite, loStray;

  assign hiWrite = wrEn && wrHi;
  assign loWrite = wrEn && !wrHi;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    loStray   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (hiWrite) begin
          strobe.loadHi = 1'b1;
          stateNext     = ST_HI_WAIT;
        end else if (loWrite) begin
          loStray = 1'b1;
        end
      end
      ST_HI_WAIT: begin
        if (loWrite) loStray = 1'b1;
        if (ackCnt == '0) stateNext = ST_ARMED;
      end
      ST_ARMED: begin
        if (hiWrite) begin
          strobe.loadHi = 1'b1;
          stateNext     = ST_HI_WAIT;
        end else if (loWrite) begin
          strobe.loadLo = 1'b1;
          stateNext     = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (cmdDone) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      ackCnt   <= '0;
      protoErr <= 1'b0;
      cmdStart <= 1'b0;
    end else begin
      state    <= stateNext;
      cmdStart <= strobe.loadLo;
      if (strobe.loadHi) ackCnt <= CNT_LOAD;
      else if (state == ST_HI_WAIT && ackCnt != '0) ackCnt <= ackCnt - 1'b1;
      if (loStray) protoErr <= 1'b1;
    end
  end

  assign ready    = (state == ST_IDLE) || (state == ST_ARMED);
  assign expectLo = (state == ST_ARMED);
  assign busy     = (state == ST_BUSY);

  p_start_follows_lo_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARMED && loWrite) |=> (cmdStart && busy));

  p_start_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> !cmdStart);

  p_busy_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cmdDone) |=> (busy && !ready));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

  p_busy_no_err_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !protoErr) |=> !protoErr);
endmodule

// File: rtl/mbox_dpath.sv
module mbox_dpath
  import mbox_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ALIGN_BITS = 4
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  mboxStrobe_t                              strobe,
  input  logic [DATA_W-1:0]                        wrData,
  input  logic                                     ready,
  input  logic                                     expectLo,
  input  logic                                     protoErr,
  output logic [2*(DATA_W-FLAG_BITS)+ALIGN_BITS-1:0] cmdAddr,
  output logic [DATA_W-1:0]                        rdData
);
  localparam int FIELD_W = DATA_W - FLAG_BITS;

  logic [FIELD_W-1:0] hiField, loField;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiField <= '0;
      loField <= '0;
    end else begin
      if (strobe.loadHi) hiField <= wrData[DATA_W-1:FLAG_BITS];
      if (strobe.loadLo) loField <= wrData[DATA_W-1:FLAG_BITS];
    end
  end

  generate
    if (ALIGN_BITS > 0) begin : g_aligned
      assign cmdAddr = {hiField, loField, {ALIGN_BITS{1'b0}}};
    end else begin : g_unaligned
      assign cmdAddr = {hiField, loField};
    end
  endgenerate

  always_comb begin
    rdData          = '0;
    rdData[RDY_BIT] = ready;
    rdData[HI_BIT]  = expectLo;
    rdData[ERR_BIT] = protoErr;
  end

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && !expectLo && !strobe.loadHi && !strobe.loadLo) |=> $stable(loField));
endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell
  import mbox_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ALIGN_BITS = 4,
  parameter int ACK_CYCLES = 2
) (
  input  logic                                       clk,
  input  logic                                       rstN,
  input  logic                                       wrEn,
  input  logic [DATA_W-1:0]                          wrData,
  output logic [DATA_W-1:0]                          rdData,
  output logic                                       cmdStart,
  output logic [2*(DATA_W-FLAG_BITS)+ALIGN_BITS-1:0] cmdAddr,
  input  logic                                       cmdDone
);
  mboxStrobe_t strobe;
  logic ready, expectLo, protoErr, busy;

  mbox_ctrl #(.ACK_CYCLES(ACK_CYCLES)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrHi     (wrData[HI_BIT]),
    .cmdDone  (cmdDone),
    .strobe   (strobe),
    .ready    (ready),
    .expectLo (expectLo),
    .protoErr (protoErr),
    .cmdStart (cmdStart),
    .busy     (busy)
  );

  mbox_dpath #(.DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .ready    (ready),
    .expectLo (expectLo),
    .protoErr (protoErr),
    .cmdAddr  (cmdAddr),
    .rdData   (rdData)
  );

  p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cmdStart) |-> $stable(cmdAddr));

  p_start_not_ready_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |-> !rdData[RDY_BIT]);
endmodule

// File: tb/test_mbox_doorbell.sv
module test_mbox_doorbell;
  localparam int ACK = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        cmdStart;
  logic [63:0] cmdAddr;
  logic        cmdDone = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mbox_doorbell #(.DATA_W(32), .ALIGN_BITS(4), .ACK_CYCLES(ACK)) i_mbox_doorbell (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .cmdStart(cmdStart), .cmdAddr(cmdAddr), .cmdDone(cmdDone)
  );

  function automatic logic [63:0] expAddr(logic [31:0] h, logic [31:0] l);
    return {h[31:2], l[31:2], 4'b0000};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic waitAck();
    for (int i = 0; i < ACK; i++) @(negedge clk);
  endtask

  task automatic done();
    @(negedge clk); cmdDone = 1'b1;
    @(negedge clk); cmdDone = 1'b0;
  endtask

  logic [31:0] h, l, h2;
  logic [63:0] held;

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdData", 64'(rdData), 64'h1);
    chk("R1 cmdStart", 64'(cmdStart), 64'h0);

    // R2 high write and acknowledge window
    h = 32'hDEAD_BEEE; l = 32'h1234_5678;
    wr(h);
    chk("R2 ready low after hi", 64'(rdData[0]), 64'h0);
    repeat (ACK - 1) @(negedge clk);
    chk("R2 ready low at end of window", 64'(rdData[0]), 64'h0);
    @(negedge clk);
    chk("R2 ready/expect after ack", 64'(rdData[1:0]), 64'h3);

    // R3 launch
    wr(l & 32'hFFFF_FFFC);
    chk("R3 cmdStart pulse", 64'(cmdStart), 64'h1);
    chk("R3 cmdAddr", cmdAddr, expAddr(h, l));
    chk("R4 ready low on launch", 64'(rdData[0]), 64'h0);
    @(negedge clk);
    chk("R3 pulse single", 64'(cmdStart), 64'h0);

    // R6 writes while busy
    held = cmdAddr;
    wr(32'hFFFF_FFFE);
    chk("R6 no start on hi", 64'(cmdStart), 64'h0);
    wr(32'h0000_00F0);
    chk("R6 no start on lo", 64'(cmdStart), 64'h0);
    chk("R6 addr held", cmdAddr, held);
    chk("R6 rdData busy", 64'(rdData), 64'h0);

    // R4 completion
    done();
    chk("R4 idle after done", 64'(rdData), 64'h1);

    // R8 stray done
    done();
    chk("R8 done ignored", 64'(rdData), 64'h1);
    chk("R8 no start", 64'(cmdStart), 64'h0);

    // R5 low write in idle
    wr(32'h0000_1000);
    chk("R5 no start", 64'(cmdStart), 64'h0);
    chk("R5 err set, ready kept", 64'(rdData), 64'h5);

    // R7 high rewrite, plus low inside ack window (R5)
    h = 32'h1111_2222; h2 = 32'hABCD_0126; l = 32'h0F0F_0F0C;
    wr(h);
    waitAck();
    wr(h2);
    chk("R7 ack restarted", 64'(rdData[0]), 64'h0);
    wr(l);
    chk("R5 lo in ack window no start", 64'(cmdStart), 64'h0);
    waitAck();
    chk("R7 armed again", 64'(rdData[1:0]), 64'h3);
    wr(l);
    chk("R7 new upper field", cmdAddr, expAddr(h2, l));
    chk("R7 start", 64'(cmdStart), 64'h1);
    done();
    chk("R9 err sticky", 64'(rdData), 64'h5);

    // Random transactions
    for (int t = 0; t < 40; t++) begin
      h = {$urandom(), 2'b10} ;
      h = {h[31:2], 2'b10};
      l = $urandom();
      l[1] = 1'b0;
      wr(h);
      waitAck();
      wr(l);
      chk("R3 random start", 64'(cmdStart), 64'h1);
      chk("R3 random addr", cmdAddr, expAddr(h, l));
      for (int k = 0; k < int'($urandom_range(0, 4)); k++) begin
        wr($urandom());
        chk("R6 random busy write dropped", cmdAddr, expAddr(h, l));
      end
      chk("R4 random busy", 64'(rdData[0]), 64'h0);
      done();
      chk("R4 random idle", 64'(rdData[1:0]), 64'h1);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule